// File: doc/BRIEF.md
# Windowed Video-Memory Block Copier

This block copies data into a video memory window in units of 16-byte blocks. Software programs a 16-bit source pointer and a destination pointer one byte at a time, then writes a control byte. The control byte gives the number of blocks and picks the pacing. A general transfer runs at once, one byte per clock. A paced transfer moves a single block each time the horizontal-blank input rises. The destination is always kept inside the 8 KiB window at 0x8000–0x9FFF. Low address nibbles are forced to zero, so every block is aligned.

Memory is reached through a read port with one cycle of latency and a separate write port. Each byte read in one cycle is written to the destination in the next cycle. A `busy` output combines this engine's activity with an externally supplied sprite-copy busy flag. A paced transfer can be cancelled through the control register.

The engine has four states. IDLE holds no transfer. HOLD waits for a blanking edge. COPY issues one read per cycle. FLUSH lets the final write drain. The transitions are as follows:
- Any state goes to COPY on a general start and to HOLD on a paced start.
- HOLD goes to COPY on a blanking rise.
- COPY goes to HOLD after the sixteenth read of a block that is not the last, in paced mode.
- COPY goes to FLUSH after the last read of the last block.
- FLUSH goes to IDLE on the next cycle.
- Any state goes to IDLE on a cancel.

Top module: `vram_block_dma`

## Requirements
- R1: After reset, the control readback is 0xFF, `busy` is 0, and neither memory strobe is asserted.
- R2: Register offsets are 0 for source high, 1 for source low, 2 for destination high and 3 for destination low. A high write sets address bits 15:8. A low write sets bits 7:0, with bits 3:0 forced to zero.
- R3: Writing offset 4 (control) starts a transfer of (bits 6:0 + 1) blocks of 16 bytes each. The first read is issued in the cycle after the write edge.
- R4: Bit 7 of the control write selects the mode. A 0 selects general mode, which copies continuously. A 1 selects paced mode, which waits for blanking edges.
- R5: At start, the destination becomes 0x8000 | (destination & 0x1FFF).
- R6: Memory reads have a latency of one cycle. A write is issued one cycle after each read, using the data returned for that read. A general transfer of N bytes clears `busy` N+1 cycles after the start edge.
- R7: The source pointer increments through all 16 bits. The destination pointer increments within the window and wraps from 0x9FFF to 0x8000.
- R8: In paced mode, exactly one 16-byte block is copied per rising edge of `hblank`. A level held high does not copy further blocks. The engine goes idle after the last block.
- R9: While a paced transfer is active, a control write with bit 7 clear stops it: the pending count becomes zero, activity clears and no transfer starts. In every other case, a control write starts a new transfer.
- R10: The control readback is {~active, (remaining blocks − 1) mod 128}. An idle engine therefore reads back with bit 7 set.
- R11: `busy` is high whenever the copy engine is active or `spr_busy` is high.
- R12: Reads of any offset other than 4 return 0xFF. Writes to offsets 5–7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| hblank | input | 1 | Horizontal-blank level |
| spr_busy | input | 1 | Sprite-copy engine active |
| mem_rd_en | output | 1 | Source read strobe |
| mem_rd_addr | output | 16 | Source read address |
| mem_rdata | input | 8 | Read data, valid one cycle after the strobe |
| mem_wr_en | output | 1 | Destination write strobe |
| mem_wr_addr | output | 16 | Destination write address |
| mem_wr_data | output | 8 | Destination write data |
| busy | output | 1 | Copy engine or sprite engine active |

## Verification
A register write takes effect at the clock edge on which it is sampled. The control readback and the first read strobe change just after that edge. The first write strobe follows one edge later. The last block count and `busy` clear on the edge that carries the final write, which is 17 edges after a one-block start. The bench drives and samples on the falling clock edge. It counts edges from each control write and checks strobes, addresses, data and readback at exactly those offsets. Whole-block contents are checked from a byte-addressed model of the window after enough idle time. Paced checks count writes before and after each blanking edge, so any extra or missing block shows up.

// File: rtl/vbd_pkg.sv
`timescale 1ns/1ps
package vbd_pkg;
    localparam int ADDR_W = 16;
    localparam int CTRL_MODE_BIT = 7;

    localparam logic [2:0] OFS_SRC_HI = 3'd0;
    localparam logic [2:0] OFS_SRC_LO = 3'd1;
    localparam logic [2:0] OFS_DST_HI = 3'd2;
    localparam logic [2:0] OFS_DST_LO = 3'd3;
    localparam logic [2:0] OFS_CTRL   = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_COPY  = 2'd2,
        ST_FLUSH = 2'd3
    } vbd_state_e;

    typedef enum logic {
        MODE_GENERAL = 1'b0,
        MODE_PACED   = 1'b1
    } vbd_mode_e;
endpackage

// File: rtl/vbd_regs.sv
`timescale 1ns/1ps
module vbd_regs
    import vbd_pkg::*;
#(
    parameter int BLK_LOG = 4,
    parameter int WIN_LOG = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_sel,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [ADDR_W-1:0] src_prog,
    output logic [WIN_LOG-1:0] dst_prog,
    output logic              ctrl_wr,
    output logic [7:0]        ctrl_val
);
    localparam int DHI_W = WIN_LOG - 8;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_prog <= '0;
            dst_prog <= '0;
        end else if (reg_wr) begin
            unique case (reg_sel)
                OFS_SRC_HI: src_prog[ADDR_W-1:8] <= reg_wdata;
                OFS_SRC_LO: src_prog[7:0] <= {reg_wdata[7:BLK_LOG], {BLK_LOG{1'b0}}};
                OFS_DST_HI: dst_prog[WIN_LOG-1:8] <= reg_wdata[DHI_W-1:0];
                OFS_DST_LO: dst_prog[7:0] <= {reg_wdata[7:BLK_LOG], {BLK_LOG{1'b0}}};
                default: ;
            endcase
        end
    end

    assign ctrl_wr  = reg_wr && (reg_sel == OFS_CTRL);
    assign ctrl_val = reg_wdata;

    // R2: aligned low nibbles on the programmed pointers
    p_src_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_wr) && $past(reg_sel) == OFS_SRC_LO |-> src_prog[BLK_LOG-1:0] == '0);
endmodule

// File: rtl/vbd_edge.sv
`timescale 1ns/1ps
module vbd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_in;
    end

    assign rise = level_in && !level_q;
endmodule

// File: rtl/vbd_engine.sv
`timescale 1ns/1ps
module vbd_engine
    import vbd_pkg::*;
#(
    parameter int BLK_LOG = 4,
    parameter int WIN_LOG = 13,
    parameter logic [ADDR_W-WIN_LOG-1:0] WIN_TAG = 3'b100,
    parameter int LEN_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_wr,
    input  logic [7:0]         ctrl_val,
    input  logic [ADDR_W-1:0]  src_prog,
    input  logic [WIN_LOG-1:0] dst_prog,
    input  logic               blank_rise,
    input  logic [7:0]         mem_rdata,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    output logic               mem_wr_en,
    output logic [ADDR_W-1:0]  mem_wr_addr,
    output logic [7:0]         mem_wr_data,
    output logic               active,
    output logic [LEN_W:0]     blocks_left
);
    localparam logic [BLK_LOG-1:0] BLK_MAX = '1;

    vbd_state_e state_q, state_d;
    vbd_mode_e  mode_q;
    logic [ADDR_W-1:0]  src_q;
    logic [WIN_LOG-1:0] dst_q;
    logic [BLK_LOG-1:0] rd_idx_q, wr_idx_q;
    logic [LEN_W:0]     rb_left_q, blocks_q, start_len;
    logic               wr_v_q, active_q, cancel, start;

    assign cancel    = ctrl_wr && !ctrl_val[CTRL_MODE_BIT] && active_q && (mode_q == MODE_PACED);
    assign start     = ctrl_wr && !cancel;
    assign start_len = {1'b0, ctrl_val[LEN_W-1:0]} + 1'b1;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  ;
            ST_HOLD:  if (blank_rise) state_d = ST_COPY;
            ST_COPY:  if (rd_idx_q == BLK_MAX) begin
                          if (rb_left_q == 1)           state_d = ST_FLUSH;
                          else if (mode_q == MODE_PACED) state_d = ST_HOLD;
                      end
            ST_FLUSH: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        if (cancel)     state_d = ST_IDLE;
        else if (start) state_d = ctrl_val[CTRL_MODE_BIT] ? ST_HOLD : ST_COPY;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_GENERAL;
            src_q     <= '0;
            dst_q     <= '0;
            rd_idx_q  <= '0;
            wr_idx_q  <= '0;
            rb_left_q <= '0;
            blocks_q  <= '0;
            wr_v_q    <= 1'b0;
            active_q  <= 1'b0;
        end else if (cancel) begin
            rb_left_q <= '0;
            blocks_q  <= '0;
            wr_v_q    <= 1'b0;
            active_q  <= 1'b0;
        end else if (start) begin
            mode_q    <= vbd_mode_e'(ctrl_val[CTRL_MODE_BIT]);
            src_q     <= src_prog;
            dst_q     <= dst_prog;
            rd_idx_q  <= '0;
            wr_idx_q  <= '0;
            rb_left_q <= start_len;
            blocks_q  <= start_len;
            wr_v_q    <= 1'b0;
            active_q  <= 1'b1;
        end else begin
            wr_v_q <= (state_q == ST_COPY);
            if (state_q == ST_COPY) begin
                src_q    <= src_q + 1'b1;
                rd_idx_q <= rd_idx_q + 1'b1;
                if (rd_idx_q == BLK_MAX) rb_left_q <= rb_left_q - 1'b1;
            end
            if (wr_v_q) begin
                dst_q    <= dst_q + 1'b1;
                wr_idx_q <= wr_idx_q + 1'b1;
                if (wr_idx_q == BLK_MAX) begin
                    blocks_q <= blocks_q - 1'b1;
                    if (blocks_q == 1) active_q <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        mem_rd_en   = (state_q == ST_COPY);
        mem_rd_addr = src_q;
        mem_wr_en   = wr_v_q;
        mem_wr_addr = {WIN_TAG, dst_q};
        mem_wr_data = mem_rdata;
        active      = active_q;
        blocks_left = blocks_q;
    end

    // R6: a write only follows a read issued one cycle earlier
    p_wr_after_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(mem_rd_en));
    // R5: every write lands inside the window
    p_dst_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> mem_wr_addr[ADDR_W-1:WIN_LOG] == WIN_TAG);
    // R7: back-to-back writes step by one, wrapping inside the window
    p_dst_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en && $past(mem_wr_en) |->
            mem_wr_addr[WIN_LOG-1:0] == WIN_LOG'($past(mem_wr_addr[WIN_LOG-1:0]) + 1'b1));
    // R9: no reads are issued by an inactive engine
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !mem_rd_en);
endmodule

// File: rtl/vram_block_dma.sv
`timescale 1ns/1ps
module vram_block_dma
    import vbd_pkg::*;
#(
    parameter int BLK_LOG = 4,
    parameter int WIN_LOG = 13,
    parameter logic [ADDR_W-WIN_LOG-1:0] WIN_TAG = 3'b100,
    parameter int LEN_W = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  reg_sel,
    input  logic        reg_wr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        hblank,
    input  logic        spr_busy,
    output logic        mem_rd_en,
    output logic [15:0] mem_rd_addr,
    input  logic [7:0]  mem_rdata,
    output logic        mem_wr_en,
    output logic [15:0] mem_wr_addr,
    output logic [7:0]  mem_wr_data,
    output logic        busy
);
    logic [ADDR_W-1:0]  src_prog;
    logic [WIN_LOG-1:0] dst_prog;
    logic               ctrl_wr, blank_rise, active;
    logic [7:0]         ctrl_val;
    logic [LEN_W:0]     blocks_left;
    logic [LEN_W-1:0]   blk_m1;

    vbd_regs #(.BLK_LOG(BLK_LOG), .WIN_LOG(WIN_LOG)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .src_prog(src_prog), .dst_prog(dst_prog),
        .ctrl_wr(ctrl_wr), .ctrl_val(ctrl_val)
    );

    vbd_edge u_edge (
        .clk(clk), .rst_n(rst_n), .level_in(hblank), .rise(blank_rise)
    );

    vbd_engine #(.BLK_LOG(BLK_LOG), .WIN_LOG(WIN_LOG), .WIN_TAG(WIN_TAG), .LEN_W(LEN_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_val(ctrl_val),
        .src_prog(src_prog), .dst_prog(dst_prog), .blank_rise(blank_rise),
        .mem_rdata(mem_rdata), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .active(active), .blocks_left(blocks_left)
    );

    assign blk_m1 = LEN_W'(blocks_left - 1'b1);

    always_comb begin
        reg_rdata = 8'hFF;
        if (reg_sel == OFS_CTRL) reg_rdata = {~active, blk_m1};
    end

    assign busy = active || spr_busy;

    // R10: an idle block always reports inactive in the control readback
    p_idle_readback_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && reg_sel == OFS_CTRL |-> reg_rdata[7]);
endmodule

// File: tb/vram_block_dma_test.sv
`timescale 1ns/1ps
module vram_block_dma_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        hblank = 1'b0;
    logic        spr_busy = 1'b0;
    logic        mem_rd_en, mem_wr_en, busy;
    logic [15:0] mem_rd_addr, mem_wr_addr;
    logic [7:0]  mem_rdata, mem_wr_data;

    int checks = 0;
    int fails = 0;
    int wr_count = 0;
    logic [7:0] rd_q = 8'h00;
    logic [7:0] vram [0:8191];

    always #10 clk = ~clk;

    vram_block_dma uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hblank(hblank),
        .spr_busy(spr_busy), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .busy(busy)
    );

    function automatic logic [7:0] src_byte(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) rd_q <= src_byte(mem_rd_addr);
        if (mem_wr_en) begin
            vram[mem_wr_addr[12:0]] <= mem_wr_data;
            wr_count <= wr_count + 1;
        end
    end
    assign mem_rdata = rd_q;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] sel, input logic [7:0] val);
        reg_sel = sel; reg_wdata = val; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 3'd4;
    endtask

    task automatic read_ctrl(input logic [2:0] sel, output logic [7:0] v);
        reg_sel = sel; #1; v = reg_rdata; reg_sel = 3'd4;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_block(input string req, input logic [15:0] src, input logic [12:0] dst, input int n);
        for (int i = 0; i < n; i++)
            chk(req, vram[13'(dst + 13'(i))], src_byte(16'(src + 16'(i))));
    endtask

    task automatic t_reset;
        logic [7:0] v;
        read_ctrl(3'd4, v);
        chk("R1 readback", v, 8'hFF);
        chk("R1 busy", busy, 0);
        chk("R1 strobes", {mem_rd_en, mem_wr_en}, 0);
    endtask

    task automatic t_general;
        logic [7:0] v;
        int base;
        reg_write(3'd0, 8'h12); reg_write(3'd1, 8'h37);
        reg_write(3'd2, 8'hE1); reg_write(3'd3, 8'h2F);
        base = wr_count;
        reg_write(3'd4, 8'h01);
        read_ctrl(3'd4, v);
        chk("R10 start readback", v, 8'h01);
        chk("R3 first read strobe", mem_rd_en, 1);
        chk("R2 source aligned", mem_rd_addr, 16'h1230);
        chk("R4 general no write yet", mem_wr_en, 0);
        wait_cycles(1);
        chk("R6 write strobe", mem_wr_en, 1);
        chk("R5 clamped destination", mem_wr_addr, 16'h8120);
        chk("R6 write data", mem_wr_data, src_byte(16'h1230));
        wait_cycles(16);
        read_ctrl(3'd4, v);
        chk("R10 one block left", v, 8'h00);
        wait_cycles(15);
        chk("R6 busy before end", busy, 1);
        wait_cycles(1);
        chk("R6 busy cleared", busy, 0);
        read_ctrl(3'd4, v);
        chk("R10 idle readback", v, 8'hFF);
        chk("R3 byte count", wr_count - base, 32);
        check_block("R3 data", 16'h1230, 13'h0120, 32);
    endtask

    task automatic t_wrap;
        reg_write(3'd0, 8'hFF); reg_write(3'd1, 8'hF0);
        reg_write(3'd2, 8'h9F); reg_write(3'd3, 8'hF0);
        reg_write(3'd4, 8'h01);
        wait_cycles(40);
        chk("R7 done", busy, 0);
        check_block("R7 window top", 16'hFFF0, 13'h1FF0, 16);
        check_block("R7 wrapped", 16'h0000, 13'h0000, 16);
    endtask

    task automatic t_paced;
        logic [7:0] v;
        int base;
        reg_write(3'd0, 8'h40); reg_write(3'd1, 8'h00);
        reg_write(3'd2, 8'h88); reg_write(3'd3, 8'h00);
        base = wr_count;
        reg_write(3'd4, 8'h82);
        read_ctrl(3'd4, v);
        chk("R4 paced readback", v, 8'h02);
        wait_cycles(30);
        chk("R8 no copy without blank", wr_count - base, 0);
        chk("R8 waiting busy", busy, 1);
        hblank = 1'b1;
        wait_cycles(40);
        chk("R8 one block per edge", wr_count - base, 16);
        read_ctrl(3'd4, v);
        chk("R8 count after block", v, 8'h01);
        hblank = 1'b0; wait_cycles(5);
        hblank = 1'b1; wait_cycles(3); hblank = 1'b0;
        wait_cycles(25);
        chk("R8 second block", wr_count - base, 32);
        check_block("R8 data", 16'h4000, 13'h0800, 32);
        reg_write(3'd6, 8'h00);
        read_ctrl(3'd4, v);
        chk("R12 unmapped write ignored", v, 8'h00);
        read_ctrl(3'd5, v);
        chk("R12 unmapped read", v, 8'hFF);
        read_ctrl(3'd0, v);
        chk("R12 write-only read", v, 8'hFF);
        reg_write(3'd4, 8'h00);
        read_ctrl(3'd4, v);
        chk("R9 cancel readback", v, 8'hFF);
        chk("R9 cancel busy", busy, 0);
        hblank = 1'b1; wait_cycles(3); hblank = 1'b0;
        wait_cycles(25);
        chk("R9 no copy after cancel", wr_count - base, 32);
        reg_write(3'd4, 8'h80);
        hblank = 1'b1; wait_cycles(3); hblank = 1'b0;
        wait_cycles(25);
        chk("R8 last block completes", busy, 0);
        chk("R8 last block count", wr_count - base, 48);
    endtask

    task automatic t_restart;
        logic [7:0] v;
        reg_write(3'd4, 8'h7F);
        read_ctrl(3'd4, v);
        chk("R3 max length readback", v, 8'h7F);
        wait_cycles(10);
        reg_write(3'd4, 8'h00);
        read_ctrl(3'd4, v);
        chk("R9 general restart", v, 8'h00);
        wait_cycles(20);
        chk("R9 restart finishes", busy, 0);
    endtask

    task automatic t_busy;
        spr_busy = 1'b1; #1;
        chk("R11 sprite busy", busy, 1);
        spr_busy = 1'b0; #1;
        chk("R11 both idle", busy, 0);
    endtask

    initial begin
        wait_cycles(3);
        rst_n = 1'b1;
        wait_cycles(1);
        t_reset;
        t_general;
        t_wrap;
        t_paced;
        t_restart;
        t_busy;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule